// File: doc/BRIEF.md
# Dual-Mode Serial Port with Receive and Transmit Status

A byte-wide serial port that frames data either asynchronously (start bit, eight data bits, optional parity bit, stop bit) or clock-synchronously (eight bare data bits with a bit clock driven out on `sclk`). Software reaches four byte-wide registers through a single-cycle write strobe and a combinational read path. Writing the data register queues a byte for the transmitter. The receiver places each completed byte in a holding register and reports the outcome through status flags and three one-cycle interrupt request pulses.

Bit timing comes from a programmable divider. The divider produces one tick every `divisor + 1` clocks, and sixteen ticks make one bit period. In asynchronous mode the receiver finds a falling start edge, confirms it at mid-bit and samples every later bit at its middle. When a frame ends, the result is classified by a fixed precedence: a bad stop bit first, then a parity mismatch, then a byte that was never collected. Any of these errors halts the receiver until software clears the flag. In synchronous mode the receiver never hunts for data by itself. It shifts in a byte only alongside a byte being transmitted.

Top module: `dm_serial_port`

## Requirements
- R1: After reset the status register (address 2) reads 0x02 (only transmit-empty set), the mode and control registers (addresses 0, 1) read 0, `txd` and `sclk` are high and no interrupt request is active.
- R2: In asynchronous mode, with receive-enable (control bit 0) set, a frame that has a valid stop bit sets receive-full (status bit 0) and loads the received byte, least significant bit first, into the data register (address 3). With receive-interrupt-enable (control bit 1) set, it pulses `rxiReq`.
- R3: A frame whose stop bit samples low sets framing-error (status bit 2) only: no other flag changes, the data register keeps its old byte even if the parity was also wrong, and `eriReq` pulses when receive interrupts are enabled.
- R4: With parity enabled (mode bit 0) and a good stop bit, a parity mismatch sets parity-error (status bit 3) and leaves the data register unchanged. Mode bit 1 selects odd parity (1) or even parity (0), counted over data and parity bit together.
- R5: A good frame that ends while receive-full is still set sets overrun (status bit 4) and keeps the earlier byte in the data register.
- R6: With receive-interrupt-enable clear, completed frames raise neither `rxiReq` nor `eriReq`, though the flags still update.
- R7: While any error flag is set the receiver ignores the line. Once the flags are cleared and receive-enable is set, asynchronous reception resumes with the next frame.
- R8: A status write clears each of bits 0, 2, 3 and 4 that is written as 0 and leaves each bit written as 1 unchanged. Reading the data register does not clear receive-full.
- R9: A data-register write clears transmit-empty (status bit 1). The byte then moves to the shift register, transmit-empty sets again, `txiReq` pulses if transmit-interrupt-enable (control bit 2) is set, and `txd` sends a low start bit, the data LSB first, the parity bit if enabled, and a high stop bit, each 16 ticks long.
- R10: The transmitted parity bit makes the count of ones in data plus parity even when mode bit 1 is 0 and odd when it is 1.
- R11: In synchronous mode (mode bit 2) the transmitter sends no start, parity or stop bit, only eight data bits LSB first. Each bit is stable while `sclk` is low in its first half and rises at mid-bit. In asynchronous mode `sclk` stays high.
- R12: In synchronous mode a transmission that starts while the receiver is idle and error-free also starts the receiver, which samples `rxd` at each `sclk` rise and reports the byte as in R2. Without a transmission, activity on `rxd` is not received.
- R13: With receive-enable clear in asynchronous mode, frames on `rxd` change neither the flags nor the data register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| divisor | input | DIV_W | Tick every divisor+1 clocks; 16 ticks per bit |
| regSel | input | 2 | Register address: 0 mode, 1 control, 2 status, 3 data |
| wrEn | input | 1 | Write strobe for the addressed register |
| wrData | input | DATA_BITS | Write data |
| rdData | output | DATA_BITS | Read data of the addressed register (combinational) |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line, idles high |
| sclk | output | 1 | Synchronous-mode bit clock, idles high |
| rxiReq | output | 1 | One-cycle pulse: byte received without error |
| eriReq | output | 1 | One-cycle pulse: frame ended with an error flag set |
| txiReq | output | 1 | One-cycle pulse: byte moved to the transmit shift register |

## Verification
A receive state machine stuck in the wrong phase shows up on the status register within one frame time: the flags report a framing error, or the data register holds a byte shifted by one position, as soon as the stop-bit decision is taken about ten clocks into the stop bit. A flag register that gets set or cleared wrongly breaks the error precedence. This shows on the next frame that ends, as the wrong flag, a reloaded data byte, or a receiver that accepts frames while an error is pending. Transmit-side faults such as a shifted bit, a wrong parity seed or a missing start bit are visible on `txd` within the first bit period they affect. In synchronous mode a failed hand-off to the receiver leaves receive-full clear once the eighth `sclk` rise has passed.

// File: rtl/dm_serial_pkg.sv
package dm_serial_pkg;

  typedef enum logic [2:0] {
    TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP
  } txState_t;

  typedef enum logic [2:0] {
    RX_IDLE, RX_HUNT, RX_START, RX_DATA, RX_PAR, RX_STOP
  } rxState_t;

  // Strobes from control to datapath, all single-cycle
  typedef struct packed {
    logic loadTsr;   // copy holding byte into transmit shifter, seed parity
    logic shiftTx;   // advance transmit shifter, fold bit into parity
    logic clrRx;     // clear receive parity accumulator at frame start
    logic shiftRx;   // shift sampled bit into receive shifter
    logic parRx;     // fold sampled parity bit into accumulator
    logic loadRdr;   // publish received byte
  } dpStrobe_t;

  localparam logic [1:0] REG_MODE = 2'd0;
  localparam logic [1:0] REG_CTRL = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;
  localparam logic [1:0] REG_DATA = 2'd3;

endpackage

// File: rtl/dm_serial_datapath.sv
module dm_serial_datapath
  import dm_serial_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            stb,
  input  logic                 wrTdr,
  input  logic [DATA_BITS-1:0] wrData,
  input  logic                 rxBit,
  input  logic                 parOdd,
  output logic [DATA_BITS-1:0] rdr,
  output logic                 txBit,
  output logic                 txParBit,
  output logic                 rxParFail
);

  logic [DATA_BITS-1:0] tdr, tsr, rsr;
  logic txAcc, rxAcc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tdr   <= '0;
      tsr   <= '0;
      rsr   <= '0;
      rdr   <= '0;
      txAcc <= 1'b0;
      rxAcc <= 1'b0;
    end else begin
      if (wrTdr) tdr <= wrData;

      if (stb.loadTsr) begin
        tsr   <= tdr;
        txAcc <= ~parOdd;            // odd seeds 0, even seeds 1
      end else if (stb.shiftTx) begin
        tsr   <= {1'b0, tsr[DATA_BITS-1:1]};
        txAcc <= txAcc ^ tsr[0];
      end

      if (stb.clrRx) begin
        rxAcc <= 1'b0;
      end else if (stb.shiftRx) begin
        rsr   <= {rxBit, rsr[DATA_BITS-1:1]};
        rxAcc <= rxAcc ^ rxBit;
      end else if (stb.parRx) begin
        rxAcc <= rxAcc ^ rxBit;
      end

      if (stb.loadRdr) rdr <= rsr;
    end
  end

  assign txBit     = tsr[0];
  assign txParBit  = ~txAcc;
  assign rxParFail = rxAcc ^ parOdd;

endmodule

// File: rtl/dm_serial_ctrl.sv
module dm_serial_ctrl
  import dm_serial_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int OVS       = 16,   // ticks per bit, power of two
  parameter int DATA_BITS = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divisor,
  input  logic [1:0]       regSel,
  input  logic             wrEn,
  input  logic [4:0]       wrBits,
  input  logic             rxd,
  input  logic             txBit,
  input  logic             txParBit,
  input  logic             rxParFail,
  output dpStrobe_t        stb,
  output logic             rxBit,
  output logic             parOdd,
  output logic [2:0]       modeBits,
  output logic [2:0]       ctrlBits,
  output logic [4:0]       statBits,
  output logic             txd,
  output logic             sclk,
  output logic             rxiReq,
  output logic             eriReq,
  output logic             txiReq
);

  localparam int PH_W = $clog2(OVS);
  localparam int BC_W = $clog2(DATA_BITS);
  localparam logic [PH_W-1:0] PH_MID  = PH_W'(OVS/2 - 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVS - 1);
  localparam logic [PH_W-1:0] PH_HALF = PH_W'(OVS/2);
  localparam logic [BC_W-1:0] BIT_LAST = BC_W'(DATA_BITS - 1);

  logic [DIV_W-1:0] divCnt;
  logic tick;
  logic parEn, syncMode, rxEn, rxIntEn, txIntEn;
  logic rxFull, txEmpty, frameErr, parErr, overrun, anyErr;
  logic rxMeta, rxS;
  txState_t txState;
  rxState_t rxState;
  logic [PH_W-1:0] txPh, rxPh;
  logic [BC_W-1:0] txCnt, rxCnt;

  // tick generator
  assign tick = (divCnt >= divisor);
  always_ff @(posedge clk) begin
    if (!rstN || tick) divCnt <= '0;
    else               divCnt <= divCnt + 1'b1;
  end

  wire wrMode = wrEn && regSel == REG_MODE;
  wire wrCtrl = wrEn && regSel == REG_CTRL;
  wire wrStat = wrEn && regSel == REG_STAT;
  wire wrData = wrEn && regSel == REG_DATA;

  assign anyErr = frameErr | parErr | overrun;
  assign rxBit  = rxS;

  wire txEnd    = tick && txPh == PH_LAST;
  wire midBit   = tick && rxPh == PH_MID;
  wire rxEndBit = tick && rxPh == PH_LAST;
  wire txLaunch = txState == TX_IDLE && !txEmpty;
  wire syncRxGo = txLaunch && syncMode && rxState == RX_IDLE && !anyErr;
  wire huntHit  = rxState == RX_HUNT && rxEn && !syncMode && !rxS;

  wire rxFinish = (rxState == RX_STOP && midBit) ||
                  (rxState == RX_DATA && syncMode && rxEndBit && rxCnt == BIT_LAST);
  wire frameBad = rxState == RX_STOP && !rxS;
  wire parBad   = !frameBad && parEn && !syncMode && rxParFail;
  wire ovrBad   = !frameBad && !parBad && rxFull;
  wire goodByte = !frameBad && !parBad && !ovrBad;
  wire errAfter = anyErr || !goodByte;

  always_comb begin
    stb.loadTsr = txLaunch;
    stb.shiftTx = txState == TX_DATA && txEnd;
    stb.clrRx   = huntHit || syncRxGo;
    stb.shiftRx = rxState == RX_DATA && midBit;
    stb.parRx   = rxState == RX_PAR && midBit;
    stb.loadRdr = rxFinish && goodByte;
  end

  // registers and flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      {syncMode, parOdd, parEn}   <= '0;
      {txIntEn, rxIntEn, rxEn}    <= '0;
      {rxFull, frameErr, parErr, overrun} <= '0;
      txEmpty <= 1'b1;
      {rxiReq, eriReq, txiReq}    <= '0;
      rxMeta <= 1'b1;
      rxS    <= 1'b1;
    end else begin
      rxMeta <= rxd;
      rxS    <= rxMeta;
      if (wrMode) {syncMode, parOdd, parEn} <= wrBits[2:0];
      if (wrCtrl) {txIntEn, rxIntEn, rxEn}  <= wrBits[2:0];
      rxFull   <= (rxFull   & ~(wrStat & ~wrBits[0])) | (rxFinish & goodByte);
      frameErr <= (frameErr & ~(wrStat & ~wrBits[2])) | (rxFinish & frameBad);
      parErr   <= (parErr   & ~(wrStat & ~wrBits[3])) | (rxFinish & parBad);
      overrun  <= (overrun  & ~(wrStat & ~wrBits[4])) | (rxFinish & ovrBad);
      if (wrData)        txEmpty <= 1'b0;
      else if (txLaunch) txEmpty <= 1'b1;
      rxiReq <= rxFinish && rxIntEn && !errAfter;
      eriReq <= rxFinish && rxIntEn && errAfter;
      txiReq <= txLaunch && txIntEn;
    end
  end

  // transmitter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txState <= TX_IDLE;
      txPh    <= '0;
      txCnt   <= '0;
    end else if (txLaunch) begin
      txState <= syncMode ? TX_DATA : TX_START;
      txPh    <= '0;
      txCnt   <= '0;
    end else if (txState != TX_IDLE && tick) begin
      txPh <= txPh + 1'b1;
      if (txEnd) begin
        case (txState)
          TX_START: txState <= TX_DATA;
          TX_DATA: begin
            if (txCnt == BIT_LAST)
              txState <= syncMode ? TX_IDLE : (parEn ? TX_PAR : TX_STOP);
            else
              txCnt <= txCnt + 1'b1;
          end
          TX_PAR:  txState <= TX_STOP;
          default: txState <= TX_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    case (txState)
      TX_START: txd = 1'b0;
      TX_DATA:  txd = txBit;
      TX_PAR:   txd = txParBit;
      default:  txd = 1'b1;
    endcase
  end
  assign sclk = !(syncMode && txState == TX_DATA && txPh < PH_HALF);

  // receiver
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxState <= RX_IDLE;
      rxPh    <= '0;
      rxCnt   <= '0;
    end else begin
      case (rxState)
        RX_IDLE: begin
          if (syncRxGo) begin
            rxState <= RX_DATA;
            rxPh    <= '0;
            rxCnt   <= '0;
          end else if (!syncMode && rxEn && !anyErr) begin
            rxState <= RX_HUNT;
          end
        end
        RX_HUNT: begin
          if (!rxEn || syncMode) rxState <= RX_IDLE;
          else if (huntHit) begin
            rxState <= RX_START;
            rxPh    <= '0;
          end
        end
        default: begin
          if (tick) rxPh <= rxPh + 1'b1;
          case (rxState)
            RX_START: begin
              if (midBit && rxS) rxState <= RX_HUNT;
              else if (rxEndBit) begin
                rxState <= RX_DATA;
                rxCnt   <= '0;
              end
            end
            RX_DATA: begin
              if (rxEndBit) begin
                if (rxCnt != BIT_LAST)  rxCnt <= rxCnt + 1'b1;
                else if (!syncMode)     rxState <= parEn ? RX_PAR : RX_STOP;
              end
            end
            RX_PAR:  if (rxEndBit) rxState <= RX_STOP;
            default: ;
          endcase
          if (rxFinish)
            rxState <= (rxEn && !errAfter && !syncMode) ? RX_HUNT : RX_IDLE;
        end
      endcase
    end
  end

  assign modeBits = {syncMode, parOdd, parEn};
  assign ctrlBits = {txIntEn, rxIntEn, rxEn};
  assign statBits = {overrun, parErr, frameErr, txEmpty, rxFull};

  AST_ERI_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    eriReq |-> anyErr);                                              // R3
  AST_RXI_FULL: assert property (@(posedge clk) disable iff (!rstN)
    rxiReq |-> rxFull);                                              // R2
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (rxiReq || eriReq) |-> $past(rxIntEn));                          // R6
  AST_TXI_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    txiReq |-> txState != TX_IDLE);                                  // R9
  AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rstN)
    anyErr |-> rxState == RX_IDLE);                                  // R7

endmodule

// File: rtl/dm_serial_port.sv
module dm_serial_port
  import dm_serial_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int OVS       = 16,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [DIV_W-1:0]     divisor,
  input  logic [1:0]           regSel,
  input  logic                 wrEn,
  input  logic [DATA_BITS-1:0] wrData,
  output logic [DATA_BITS-1:0] rdData,
  input  logic                 rxd,
  output logic                 txd,
  output logic                 sclk,
  output logic                 rxiReq,
  output logic                 eriReq,
  output logic                 txiReq
);

  dpStrobe_t stb;
  logic rxBit, parOdd, txBit, txParBit, rxParFail;
  logic [2:0] modeBits, ctrlBits;
  logic [4:0] statBits;
  logic [DATA_BITS-1:0] rdr;

  dm_serial_ctrl #(.DIV_W(DIV_W), .OVS(OVS), .DATA_BITS(DATA_BITS)) ctrl (
    .clk(clk), .rstN(rstN), .divisor(divisor), .regSel(regSel), .wrEn(wrEn),
    .wrBits(wrData[4:0]), .rxd(rxd), .txBit(txBit), .txParBit(txParBit),
    .rxParFail(rxParFail), .stb(stb), .rxBit(rxBit), .parOdd(parOdd),
    .modeBits(modeBits), .ctrlBits(ctrlBits), .statBits(statBits),
    .txd(txd), .sclk(sclk), .rxiReq(rxiReq), .eriReq(eriReq), .txiReq(txiReq)
  );

  dm_serial_datapath #(.DATA_BITS(DATA_BITS)) dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .wrTdr(wrEn && regSel == REG_DATA), .wrData(wrData),
    .rxBit(rxBit), .parOdd(parOdd), .rdr(rdr), .txBit(txBit),
    .txParBit(txParBit), .rxParFail(rxParFail)
  );

  always_comb begin
    case (regSel)
      REG_MODE: rdData = {{(DATA_BITS-3){1'b0}}, modeBits};
      REG_CTRL: rdData = {{(DATA_BITS-3){1'b0}}, ctrlBits};
      REG_STAT: rdData = {{(DATA_BITS-5){1'b0}}, statBits};
      default:  rdData = rdr;
    endcase
  end

  AST_RDR_FRESH: assert property (@(posedge clk) disable iff (!rstN)
    (rdr != $past(rdr)) |-> (statBits[0] && !$past(statBits[0]))); // R5

endmodule

// File: tb/dm_serial_port_test.sv
module dm_serial_port_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] divisor = 8'd0;
  logic [1:0] regSel = 2'd0;
  logic wrEn = 1'b0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic rxdDrv = 1'b1;
  logic loopOn = 1'b0;
  logic rxd, txd, sclk, rxiReq, eriReq, txiReq;

  int checks = 0;
  int errors = 0;
  int rxiCnt = 0, eriCnt = 0, txiCnt = 0;
  int cyc = 0;
  bit sclkLowSeen = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  assign rxd = loopOn ? txd : rxdDrv;

  dm_serial_port uut (
    .clk(clk), .rstN(rstN), .divisor(divisor), .regSel(regSel), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .rxd(rxd), .txd(txd), .sclk(sclk),
    .rxiReq(rxiReq), .eriReq(eriReq), .txiReq(txiReq)
  );

  always @(negedge clk) begin
    if (rxiReq) rxiCnt++;
    if (eriReq) eriCnt++;
    if (txiReq) txiCnt++;
    if (!sclk) sclkLowSeen = 1'b1;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] sel, input logic [7:0] val);
    @(negedge clk);
    regSel = sel; wrData = val; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] sel, output logic [7:0] val);
    regSel = sel;
    #1;
    val = rdData;
  endtask

  task automatic sendFrame(input logic [7:0] b, input bit withPar, input bit parBit, input bit stopBit);
    @(negedge clk);
    rxdDrv = 1'b0;
    repeat (16) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxdDrv = b[i];
      repeat (16) @(negedge clk);
    end
    if (withPar) begin
      rxdDrv = parBit;
      repeat (16) @(negedge clk);
    end
    rxdDrv = stopBit;
    repeat (16) @(negedge clk);
    rxdDrv = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic captureAsync(input string tag, input logic [7:0] expB, input bit withPar, input bit expPar);
    logic [7:0] got;
    int guard = 0;
    @(negedge clk);
    while (txd !== 1'b0 && guard < 200) begin @(negedge clk); guard++; end
    repeat (8) @(negedge clk);
    check({tag, " start bit"}, {7'd0, txd}, 8'd0);
    for (int i = 0; i < 8; i++) begin
      repeat (16) @(negedge clk);
      got[i] = txd;
    end
    check({tag, " data"}, got, expB);
    if (withPar) begin
      repeat (16) @(negedge clk);
      check({tag, " parity bit"}, {7'd0, txd}, {7'd0, expPar});
    end
    repeat (16) @(negedge clk);
    check({tag, " stop bit"}, {7'd0, txd}, 8'd1);
    repeat (20) @(negedge clk);
  endtask

  task automatic testReset();
    logic [7:0] v;
    readReg(2'd2, v); check("R1 status", v, 8'h02);
    readReg(2'd0, v); check("R1 mode", v, 8'h00);
    readReg(2'd1, v); check("R1 control", v, 8'h00);
    check("R1 lines", {4'd0, txd, sclk, rxiReq | eriReq, txiReq}, 8'b0000_1100);
  endtask

  task automatic testGoodRx();
    logic [7:0] v;
    int r0 = rxiCnt;
    writeReg(2'd1, 8'h03);
    sendFrame(8'h5A, 0, 0, 1);
    readReg(2'd2, v); check("R2 status after good frame", v, 8'h03);
    readReg(2'd3, v); check("R2 data LSB first", v, 8'h5A);
    check("R2 rxi pulse", 8'(rxiCnt - r0), 8'd1);
  endtask

  task automatic testClear();
    logic [7:0] v;
    readReg(2'd3, v);
    readReg(2'd3, v);
    readReg(2'd2, v); check("R8 read data keeps full", v, 8'h03);
    writeReg(2'd2, 8'hFF);
    readReg(2'd2, v); check("R8 write ones no effect", v, 8'h03);
    writeReg(2'd2, 8'hFE);
    readReg(2'd2, v); check("R8 write zero clears", v, 8'h02);
  endtask

  task automatic testOverrun();
    logic [7:0] v;
    int e0;
    sendFrame(8'h11, 0, 0, 1);
    e0 = eriCnt;
    sendFrame(8'h22, 0, 0, 1);
    readReg(2'd2, v); check("R5 overrun status", v, 8'h13);
    readReg(2'd3, v); check("R5 old data kept", v, 8'h11);
    check("R5 eri pulse", 8'(eriCnt - e0), 8'd1);
    sendFrame(8'h33, 0, 0, 1);
    readReg(2'd2, v); check("R7 halted status", v, 8'h13);
    readReg(2'd3, v); check("R7 halted data", v, 8'h11);
    writeReg(2'd2, 8'h00);
    repeat (4) @(negedge clk);
    readReg(2'd2, v); check("R8 clear all", v, 8'h02);
    sendFrame(8'h44, 0, 0, 1);
    readReg(2'd2, v); check("R7 resumed status", v, 8'h03);
    readReg(2'd3, v); check("R7 resumed data", v, 8'h44);
    writeReg(2'd2, 8'hFE);
  endtask

  task automatic testParity();
    logic [7:0] v;
    int e0;
    writeReg(2'd0, 8'h01);
    e0 = eriCnt;
    sendFrame(8'h03, 1, 1, 1);
    readReg(2'd2, v); check("R4 parity error status", v, 8'h0A);
    readReg(2'd3, v); check("R4 data unchanged", v, 8'h44);
    check("R4 eri pulse", 8'(eriCnt - e0), 8'd1);
    writeReg(2'd2, 8'h00);
    repeat (4) @(negedge clk);
    sendFrame(8'h07, 1, 1, 1);
    readReg(2'd2, v); check("R4 even ok status", v, 8'h03);
    readReg(2'd3, v); check("R4 even ok data", v, 8'h07);
    writeReg(2'd2, 8'hFE);
    writeReg(2'd0, 8'h03);
    sendFrame(8'h0F, 1, 1, 1);
    readReg(2'd2, v); check("R4 odd ok status", v, 8'h03);
    readReg(2'd3, v); check("R4 odd ok data", v, 8'h0F);
    writeReg(2'd2, 8'hFE);
  endtask

  task automatic testFraming();
    logic [7:0] v;
    int e0 = eriCnt;
    writeReg(2'd0, 8'h01);
    sendFrame(8'h03, 1, 1, 0);
    readReg(2'd2, v); check("R3 framing only", v, 8'h06);
    readReg(2'd3, v); check("R3 data unchanged", v, 8'h0F);
    check("R3 eri pulse", 8'(eriCnt - e0), 8'd1);
    writeReg(2'd2, 8'h00);
    repeat (4) @(negedge clk);
  endtask

  task automatic testNoIrq();
    logic [7:0] v;
    int r0, e0;
    writeReg(2'd0, 8'h00);
    writeReg(2'd1, 8'h01);
    r0 = rxiCnt; e0 = eriCnt;
    sendFrame(8'h81, 0, 0, 1);
    readReg(2'd2, v); check("R6 flag still set", v, 8'h03);
    check("R6 no request", 8'(rxiCnt - r0 + eriCnt - e0), 8'd0);
    writeReg(2'd2, 8'hFE);
  endtask

  task automatic testRxOff();
    logic [7:0] v;
    writeReg(2'd1, 8'h00);
    sendFrame(8'h55, 0, 0, 1);
    readReg(2'd2, v); check("R13 status unchanged", v, 8'h02);
    readReg(2'd3, v); check("R13 data unchanged", v, 8'h81);
  endtask

  task automatic testTxAsync();
    logic [7:0] v;
    int t0 = txiCnt;
    writeReg(2'd1, 8'h04);
    writeReg(2'd0, 8'h01);
    sclkLowSeen = 1'b0;
    writeReg(2'd3, 8'hA3);
    readReg(2'd2, v); check("R9 empty cleared by write", v, 8'h00);
    captureAsync("R10 even", 8'hA3, 1, 1'b0);
    check("R9 txi pulse", 8'(txiCnt - t0), 8'd1);
    readReg(2'd2, v); check("R9 empty again", v, 8'h02);
    writeReg(2'd0, 8'h03);
    writeReg(2'd3, 8'hA3);
    captureAsync("R10 odd", 8'hA3, 1, 1'b1);
    writeReg(2'd0, 8'h00);
    writeReg(2'd3, 8'h5C);
    captureAsync("R9 no parity", 8'h5C, 0, 1'b0);
    check("R11 sclk high in async", {7'd0, sclkLowSeen}, 8'd0);
  endtask

  task automatic testSync();
    logic [7:0] v;
    logic [7:0] got;
    logic prev;
    int r0 = rxiCnt;
    writeReg(2'd0, 8'h04);
    writeReg(2'd1, 8'h03);
    loopOn = 1'b1;
    writeReg(2'd3, 8'h3C);
    prev = sclk;
    for (int i = 0; i < 8; i++) begin
      int guard = 0;
      @(negedge clk);
      while (!(prev == 1'b0 && sclk == 1'b1) && guard < 100) begin
        prev = sclk; @(negedge clk); guard++;
      end
      got[i] = txd;
      prev = sclk;
    end
    check("R11 sync data no start bit", got, 8'h3C);
    repeat (20) @(negedge clk);
    check("R11 sclk idle high", {7'd0, sclk}, 8'd1);
    readReg(2'd2, v); check("R12 sync rx status", v, 8'h03);
    readReg(2'd3, v); check("R12 sync rx data", v, 8'h3C);
    check("R12 rxi pulse", 8'(rxiCnt - r0), 8'd1);
    writeReg(2'd2, 8'hFE);
    loopOn = 1'b0;
    sendFrame(8'h99, 0, 0, 1);
    readReg(2'd2, v); check("R12 no rx without tx", v, 8'h02);
    readReg(2'd3, v); check("R12 data unchanged", v, 8'h3C);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testGoodRx();
    testClear();
    testOverrun();
    testParity();
    testFraming();
    testNoIrq();
    testRxOff();
    testTxAsync();
    testSync();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule